// File: doc/BRIEF.md
# Interleaved PFC Phase Alternation Sequencer

This block sits between the per-module PWM generators and the gate drivers of a two-module interleaved totem-pole boost power factor correction stage. It decides, cycle by cycle, which boost module is switching. It also maps each module's PWM duty signal onto the high and low switch of that module's leg, using the present AC polarity.

At heavy load both modules switch together and share the power. At light load the block sheds one module per half line cycle. The module that switches changes at every polarity reversal, so the two modules share the heating. The block blanks every gate near each zero crossing and raises a flag that tells the current loop to zero its reference. It also swaps, every few line cycles, which module serves which polarity.

The block uses the polarity flag that the totem-pole leg already needs and adds no sensing input. The polarity flag is debounced. The heavy/light decision uses hysteresis. Any change of mode or role takes effect only where the blanking window opens.

Top module: `pfc_phase_alternator`

## Requirements
- R1: After reset, and until the first accepted polarity change, iref_zero is 1 and every gate_hi, gate_lo and mod_en bit is 0, whatever the other inputs do.
- R2: The accepted polarity (reset value 0 = negative) flips only after pol_raw has differed from it on DEB_SAMPLES consecutive rising clock edges; a shorter excursion of pol_raw leaves the gates unchanged.
- R3: While near_zc is 1, iref_zero is 1 and all gate and mod_en outputs are 0 in the same cycle.
- R4: In shared mode, outside the blanking window, both mod_en bits are 1.
- R5: For an enabled module i, accepted polarity 1 (positive) gives gate_lo[i] = pwm_duty[i] and gate_hi[i] = NOT pwm_duty[i]; polarity 0 gives gate_hi[i] = pwm_duty[i] and gate_lo[i] = NOT pwm_duty[i]; a disabled module has both gates at 0.
- R6: In alternating mode, outside the blanking window, exactly one module is enabled: the module named by the role bit (reset value 0, meaning module 0) on positive polarity, and the other module on negative polarity.
- R7: An internal light-load request, registered on each clock edge, becomes 1 when pwr_meas <= pwr_thr, becomes 0 when pwr_meas > pwr_thr + pwr_hyst, and otherwise keeps its value; its reset value is 0 (shared mode).
- R8: The mode register copies the light-load request only on a clock edge where near_zc is 1 after being 0 on the previous edge, or while no polarity change has been accepted yet; at all other times the mode does not change.
- R9: Every swap_cycles accepted polarity changes from 0 to 1 arm a swap. An armed swap flips the role bit at the next edge where the mode may be loaded (R8). When swap_cycles is 0, no swap is ever armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pol_raw | input | 1 | Raw AC polarity flag, 1 = positive half cycle |
| near_zc | input | 1 | High inside the zero-crossing blanking window |
| pwr_meas | input | PWR_W | Measured output power |
| pwr_thr | input | PWR_W | Light-load threshold |
| pwr_hyst | input | PWR_W | Hysteresis added to the threshold for leaving light mode |
| swap_cycles | input | CYC_W | Line cycles between role swaps, 0 disables swapping |
| pwm_duty | input | 2 | PWM boost-switch command per module |
| gate_hi | output | 2 | High-side gate per module |
| gate_lo | output | 2 | Low-side gate per module |
| mod_en | output | 2 | Module switching enable per module |
| iref_zero | output | 1 | Request to force the current reference to zero |

## Verification
The hardest situation to create is an armed role swap that meets a change in the power mode. The two must be applied together at the opening of a blanking window, while the polarity edge that armed the swap falls inside that same window. Only a long run of line cycles with a small swap interval produces this. The stimulus drives a half-cycle generator with random half-cycle lengths, random swap intervals of 0 to 3 and random power levels that change in the middle of a half cycle, so swaps and mode changes pile up on the same window. Directed half cycles add the rest: power set exactly at the hysteresis edge, and polarity glitches one sample shorter than the debounce length.

// File: rtl/pfc_alt_pkg.sv
package pfc_alt_pkg;
  localparam int NUM_MOD = 2;

  typedef enum logic {
    MODE_SHARED = 1'b0,
    MODE_ALT    = 1'b1
  } pfc_mode_e;
endpackage

// File: rtl/pfc_pol_debounce.sv
module pfc_pol_debounce #(
  parameter int DEB_SAMPLES = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pol_raw,
  output logic pol_ok,
  output logic started,
  output logic rise_evt
);
  localparam int CNT_W = $clog2(DEB_SAMPLES + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DEB_SAMPLES - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             pol_q, pol_d;
  logic             start_q, start_d;
  logic             accept;

  always_comb begin
    accept  = (pol_raw != pol_q) && (cnt_q == CNT_LAST);
    cnt_d   = '0;
    pol_d   = pol_q;
    start_d = start_q;
    if (pol_raw != pol_q) begin
      if (accept) begin
        pol_d   = pol_raw;
        start_d = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      pol_q   <= 1'b0;
      start_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      pol_q   <= pol_d;
      start_q <= start_d;
    end
  end

  assign pol_ok   = pol_q;
  assign started  = start_q;
  assign rise_evt = accept && !pol_q;
endmodule

// File: rtl/pfc_load_mode.sv
module pfc_load_mode #(
  parameter int PWR_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PWR_W-1:0] pwr_meas,
  input  logic [PWR_W-1:0] pwr_thr,
  input  logic [PWR_W-1:0] pwr_hyst,
  output logic             light_req
);
  logic [PWR_W:0] exit_lvl;
  logic           light_q, light_d;

  always_comb begin
    exit_lvl = {1'b0, pwr_thr} + {1'b0, pwr_hyst};
    light_d  = light_q;
    if (light_q) begin
      if ({1'b0, pwr_meas} > exit_lvl) light_d = 1'b0;
    end else begin
      if (pwr_meas <= pwr_thr) light_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) light_q <= 1'b0;
    else        light_q <= light_d;
  end

  assign light_req = light_q;
endmodule

// File: rtl/pfc_role_seq.sv
module pfc_role_seq
  import pfc_alt_pkg::*;
#(
  parameter int CYC_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             near_zc,
  input  logic             started,
  input  logic             rise_evt,
  input  logic             light_req,
  input  logic [CYC_W-1:0] swap_cycles,
  output pfc_mode_e        mode_q,
  output logic             role_q,
  output logic             dz_start
);
  logic             nzc_q;
  logic             load_en;
  logic             pend_q, pend_d;
  logic             role_d;
  pfc_mode_e        mode_d;
  logic [CYC_W-1:0] ccnt_q, ccnt_d;
  logic             arm;

  always_comb begin
    dz_start = near_zc && !nzc_q;
    load_en  = dz_start || !started;
    arm      = rise_evt && (swap_cycles != '0) &&
               (({1'b0, ccnt_q} + 1'b1) >= {1'b0, swap_cycles});
    ccnt_d   = ccnt_q;
    if (swap_cycles == '0)  ccnt_d = '0;
    else if (arm)           ccnt_d = '0;
    else if (rise_evt)      ccnt_d = ccnt_q + 1'b1;
    pend_d = arm || (pend_q && !load_en);
    role_d = load_en ? (role_q ^ pend_q) : role_q;
    mode_d = load_en ? (light_req ? MODE_ALT : MODE_SHARED) : mode_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nzc_q  <= 1'b0;
      pend_q <= 1'b0;
      role_q <= 1'b0;
      mode_q <= MODE_SHARED;
      ccnt_q <= '0;
    end else begin
      nzc_q  <= near_zc;
      pend_q <= pend_d;
      role_q <= role_d;
      mode_q <= mode_d;
      ccnt_q <= ccnt_d;
    end
  end
endmodule

// File: rtl/pfc_leg_drive.sv
module pfc_leg_drive (
  input  logic en,
  input  logic pol_pos,
  input  logic duty,
  output logic g_hi,
  output logic g_lo
);
  always_comb begin
    g_hi = 1'b0;
    g_lo = 1'b0;
    if (en) begin
      if (pol_pos) begin
        g_lo = duty;
        g_hi = !duty;
      end else begin
        g_hi = duty;
        g_lo = !duty;
      end
    end
  end
endmodule

// File: rtl/pfc_phase_alternator.sv
module pfc_phase_alternator
  import pfc_alt_pkg::*;
#(
  parameter int PWR_W       = 12,
  parameter int CYC_W       = 4,
  parameter int DEB_SAMPLES = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               pol_raw,
  input  logic               near_zc,
  input  logic [PWR_W-1:0]   pwr_meas,
  input  logic [PWR_W-1:0]   pwr_thr,
  input  logic [PWR_W-1:0]   pwr_hyst,
  input  logic [CYC_W-1:0]   swap_cycles,
  input  logic [NUM_MOD-1:0] pwm_duty,
  output logic [NUM_MOD-1:0] gate_hi,
  output logic [NUM_MOD-1:0] gate_lo,
  output logic [NUM_MOD-1:0] mod_en,
  output logic               iref_zero
);
  logic      pol_ok;
  logic      started;
  logic      rise_evt;
  logic      light_req;
  pfc_mode_e mode_q;
  logic      role_q;
  logic      dz_start;
  logic      blank;
  logic      act_mod;

  pfc_pol_debounce #(.DEB_SAMPLES(DEB_SAMPLES)) u_deb (
    .clk(clk), .rst_n(rst_n), .pol_raw(pol_raw),
    .pol_ok(pol_ok), .started(started), .rise_evt(rise_evt)
  );

  pfc_load_mode #(.PWR_W(PWR_W)) u_load (
    .clk(clk), .rst_n(rst_n), .pwr_meas(pwr_meas),
    .pwr_thr(pwr_thr), .pwr_hyst(pwr_hyst), .light_req(light_req)
  );

  pfc_role_seq #(.CYC_W(CYC_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .near_zc(near_zc), .started(started),
    .rise_evt(rise_evt), .light_req(light_req), .swap_cycles(swap_cycles),
    .mode_q(mode_q), .role_q(role_q), .dz_start(dz_start)
  );

  assign blank     = near_zc || !started;
  assign act_mod   = pol_ok ? role_q : !role_q;
  assign iref_zero = blank;

  for (genvar i = 0; i < NUM_MOD; i++) begin : g_leg
    assign mod_en[i] = !blank &&
                       ((mode_q == MODE_SHARED) || (act_mod == 1'(i)));
    pfc_leg_drive u_leg (
      .en(mod_en[i]), .pol_pos(pol_ok), .duty(pwm_duty[i]),
      .g_hi(gate_hi[i]), .g_lo(gate_lo[i])
    );
  end
endmodule

// File: rtl/pfc_phase_alternator_chk.sv
module pfc_phase_alternator_chk
  import pfc_alt_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               pol_raw,
  input logic               near_zc,
  input logic [NUM_MOD-1:0] gate_hi,
  input logic [NUM_MOD-1:0] gate_lo,
  input logic [NUM_MOD-1:0] mod_en,
  input logic               iref_zero,
  input logic               started,
  input logic               pol_ok,
  input pfc_mode_e          mode_q,
  input logic               dz_start
);
  AST_PRESTART_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
    !started |-> (iref_zero && mod_en == '0 && gate_hi == '0 && gate_lo == '0)); // R1

  AST_POL_DEBOUNCED: assert property (@(posedge clk) disable iff (!rst_n)
    (pol_ok != $past(pol_ok)) |-> ($past(pol_raw) == pol_ok)); // R2

  AST_ZC_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
    near_zc |-> (iref_zero && gate_hi == '0 && gate_lo == '0 && mod_en == '0)); // R3

  AST_SHARED_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_SHARED && !iref_zero) |-> (mod_en == '1)); // R4

  AST_NO_SHOOT: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_hi & gate_lo) == '0); // R5

  AST_ALT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_ALT && !iref_zero) |-> ($countones(mod_en) == 1)); // R6

  AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (started && !dz_start) |=> $stable(mode_q)); // R8
endmodule

bind pfc_phase_alternator pfc_phase_alternator_chk u_chk (
  .clk(clk), .rst_n(rst_n), .pol_raw(pol_raw), .near_zc(near_zc),
  .gate_hi(gate_hi), .gate_lo(gate_lo), .mod_en(mod_en),
  .iref_zero(iref_zero), .started(started), .pol_ok(pol_ok),
  .mode_q(mode_q), .dz_start(dz_start)
);

// File: tb/pfc_phase_alternator_bench.sv
`timescale 1ns/1ps
module pfc_phase_alternator_bench;
  localparam int PWR_W = 12;
  localparam int CYC_W = 4;
  localparam int DEB   = 3;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             pol_raw, near_zc;
  logic [PWR_W-1:0] pwr_meas, pwr_thr, pwr_hyst;
  logic [CYC_W-1:0] swap_cycles;
  logic [1:0]       pwm_duty, gate_hi, gate_lo, mod_en;
  logic             iref_zero;

  int total = 0;
  int bad = 0;
  string phase_tag = "R4";

  // bench reference state, updated from the requirement rules
  bit m_pol, m_started, m_light, m_nzc, m_mode, m_role, m_pend;
  int m_cnt, m_ccnt;
  bit cur_pol;

  always #2.5 clk = ~clk;

  pfc_phase_alternator #(.PWR_W(PWR_W), .CYC_W(CYC_W), .DEB_SAMPLES(DEB)) u_pfc_phase_alternator (
    .clk(clk), .rst_n(rst_n), .pol_raw(pol_raw), .near_zc(near_zc),
    .pwr_meas(pwr_meas), .pwr_thr(pwr_thr), .pwr_hyst(pwr_hyst),
    .swap_cycles(swap_cycles), .pwm_duty(pwm_duty), .gate_hi(gate_hi),
    .gate_lo(gate_lo), .mod_en(mod_en), .iref_zero(iref_zero)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pol = 0; m_started = 0; m_light = 0; m_nzc = 0;
      m_mode = 0; m_role = 0; m_pend = 0; m_cnt = 0; m_ccnt = 0;
    end else begin
      bit accept, rise, load, armv;
      int sw;
      sw     = int'(swap_cycles);
      accept = (pol_raw != m_pol) && (m_cnt == DEB - 1);
      rise   = accept && !m_pol;
      load   = (near_zc && !m_nzc) || !m_started;
      armv   = rise && (sw != 0) && (m_ccnt + 1 >= sw);
      if (load) begin
        m_role = m_role ^ m_pend;
        m_mode = m_light;
      end
      m_pend = armv || (m_pend && !load);
      if (sw == 0 || armv) m_ccnt = 0;
      else if (rise)       m_ccnt = m_ccnt + 1;
      if (m_light) begin
        if (int'(pwr_meas) > int'(pwr_thr) + int'(pwr_hyst)) m_light = 0;
      end else if (int'(pwr_meas) <= int'(pwr_thr)) m_light = 1;
      m_nzc = near_zc;
      if (pol_raw != m_pol) begin
        if (accept) begin m_pol = pol_raw; m_started = 1; m_cnt = 0; end
        else m_cnt = m_cnt + 1;
      end else m_cnt = 0;
    end
  end

  function automatic logic [6:0] expect_out();
    logic [1:0] en, hi, lo;
    bit blank, act;
    blank = near_zc || !m_started;
    act   = m_pol ? m_role : !m_role;
    for (int i = 0; i < 2; i++) begin
      en[i] = !blank && (!m_mode || (act == 1'(i)));
      hi[i] = en[i] && (m_pol ? !pwm_duty[i] : pwm_duty[i]);
      lo[i] = en[i] && (m_pol ? pwm_duty[i] : !pwm_duty[i]);
    end
    return {hi, lo, en, blank};
  endfunction

  task automatic check_now();
    logic [6:0] exp_v, got;
    string tag;
    exp_v = expect_out();
    got   = {gate_hi, gate_lo, mod_en, iref_zero};
    if (!m_started)   tag = "R1";
    else if (near_zc) tag = "R3";
    else if (phase_tag == "R4" || phase_tag == "R6")
      tag = m_mode ? "R6/R5" : "R4/R5";
    else tag = phase_tag;
    total++;
    if (got !== exp_v) begin
      bad++;
      $display("FAIL %s t=%0t hi/lo/en/iz got=%b expected=%b", tag, $time, got, exp_v);
    end
  endtask

  task automatic step();
    @(negedge clk);
    check_now();
    pwm_duty = 2'($urandom);
  endtask

  task automatic half_cycle(int h, int pa, int pb, int chg, int glitch);
    cur_pol = !cur_pol;
    for (int k = 0; k < h; k++) begin
      step();
      near_zc  = (k < DEB + 3) || (k >= h - 3);
      pwr_meas = PWR_W'((k < chg) ? pa : pb);
      pol_raw  = cur_pol;
      if (glitch >= 0 && k >= glitch && k < glitch + DEB - 1) pol_raw = !cur_pol;
    end
  endtask

  initial begin
    #(5.0 * 150000);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    rst_n = 0; pol_raw = 0; near_zc = 0; pwm_duty = 0;
    pwr_meas = 12'd3000; pwr_thr = 12'd1000; pwr_hyst = 12'd100;
    swap_cycles = 4'd2; cur_pol = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: block idles blanked until a polarity change is accepted
    phase_tag = "R1";
    for (int k = 0; k < 6; k++) step();
    // heavy load, both modules interleaved
    phase_tag = "R4";
    for (int n = 0; n < 8; n++) half_cycle(24, 3000, 3000, 24, -1);
    // light load with role swaps every two line cycles
    phase_tag = "R6";
    for (int n = 0; n < 12; n++) half_cycle(24, 500, 500, 24, -1);
    // R9: fastest swap interval, then swapping disabled
    phase_tag = "R9";
    swap_cycles = 4'd1;
    for (int n = 0; n < 8; n++) half_cycle(24, 500, 500, 24, -1);
    swap_cycles = 4'd0;
    for (int n = 0; n < 8; n++) half_cycle(24, 500, 500, 24, -1);
    swap_cycles = 4'd2;
    // R7: exactly at exit level stays light, one above leaves, between holds
    phase_tag = "R7";
    for (int n = 0; n < 4; n++) half_cycle(24, 1100, 1100, 24, -1);
    for (int n = 0; n < 4; n++) half_cycle(24, 1101, 1101, 24, -1);
    for (int n = 0; n < 4; n++) half_cycle(24, 1050, 1050, 24, -1);
    for (int n = 0; n < 4; n++) half_cycle(24, 1000, 1000, 24, -1);
    // R8: power crosses mid half cycle, mode must wait for the window
    phase_tag = "R8";
    for (int n = 0; n < 8; n++)
      half_cycle(24, (n % 2) ? 3000 : 200, (n % 2) ? 200 : 3000, 12, -1);
    // R2: short polarity glitches inside the half cycle
    phase_tag = "R2";
    for (int n = 0; n < 8; n++) half_cycle(24, 500, 500, 24, 10);
    for (int n = 0; n < 8; n++) half_cycle(24, 3000, 3000, 24, 12);
    // random mix
    phase_tag = "R6";
    for (int n = 0; n < 160; n++) begin
      int h, pa, pb;
      h  = 16 + int'($urandom % 25);
      pa = int'($urandom % 2048);
      pb = ($urandom % 3 == 0) ? int'($urandom % 2048) : pa;
      if ($urandom % 10 == 0) swap_cycles = 4'($urandom % 4);
      half_cycle(h, pa, pb, int'($urandom % h),
                 ($urandom % 2) ? h / 2 - 1 : -1);
    end
    // R1 again after a second reset
    phase_tag = "R1";
    @(negedge clk);
    rst_n = 0; near_zc = 0;
    @(negedge clk);
    rst_n = 1;
    for (int k = 0; k < 4; k++) step();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule